// File: doc/BRIEF.md
# Receive Frame Rule Walker

This block classifies each received Ethernet frame against an ordered table of match rules. Frame words arrive 32 bits at a time with start and end markers. The block keeps the first `MAX_WORDS` words of the frame. Once the last word has arrived, it walks the rule table one entry per clock. Each rule compares one masked 32-bit frame word, chosen by a word offset, against a pattern. The walk ends with a single verdict: deliver the frame on a chosen DMA channel, or drop it.

The table memory sits outside the block and is read through a combinational fetch port: the block drives an entry index and receives that entry's 92-bit word in the same cycle. Loading the table is the user's job. It may be done safely only while `idle` is high. A byte-aligned match that crosses a 4-byte word boundary is written as two chained entries that must both match. A frame that falls through every rule is delivered on channel 0.

Top module: `frame_parser`

## Requirements
- R1: During and after reset, `vd_valid` is low, and `idle` is high whenever `enable` is low.
- R2: The entry word is laid out as follows: pattern at [91:60], mask at [59:28], word offset at [27:20], jump index at [19:12], channel at [11:4]. The flags are deliver [3], drop [2], invert [1] and chain [0]. An entry hits when (frame word at its offset XOR pattern) AND mask is zero. A hit with deliver set ends the walk with `vd_accept`=1 and `vd_chan` equal to the entry channel.
- R3: A hit with drop set, and deliver clear, ends the walk with `vd_accept`=0 and `vd_chan`=0. When both flags are set, deliver wins.
- R4: An entry with invert set hits exactly when the masked compare fails.
- R5: A non-chained entry that does not hit, or that hits with neither verdict flag set, passes control to the next sequential entry.
- R6: A chained entry carries no verdict. On a hit, control goes to the entry at its jump index. On a miss, control goes to the entry after that one (jump+1).
- R7: The walk stops with deliver on channel 0 in two cases. The first is when the entry index reaches the smaller of `nve` and `npe`. The second is when `DEPTH` entries have been evaluated without a verdict, which covers a looping chain.
- R8: A frame word at an offset at or beyond the number of stored words reads as zero. Stored words are capped at `MAX_WORDS`, so later words are not kept, and words left from earlier frames are never visible.
- R9: Each frame that is accepted for parsing produces exactly one one-cycle `vd_valid` pulse. A start marker that arrives while `enable` is low, or while an earlier frame is still being captured or walked, is ignored, and that frame produces no verdict.
- R10: `idle` is high only when `enable` is low and no frame is in capture or walk. If `enable` is cleared in the middle of a frame, that frame still completes and produces its verdict, and `idle` rises afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Global parser enable |
| nve | input | 8 | Number of valid table entries |
| npe | input | 8 | Number of parsable table entries |
| rx_valid | input | 1 | Frame word valid |
| rx_sof | input | 1 | First word of a frame |
| rx_eof | input | 1 | Last word of a frame |
| rx_data | input | 32 | Frame word |
| tbl_idx | output | 8 | Index of the entry being fetched |
| tbl_entry | input | 92 | Fetched entry word (layout in R2) |
| vd_valid | output | 1 | Verdict pulse |
| vd_accept | output | 1 | 1 = deliver, 0 = drop |
| vd_chan | output | 8 | Destination DMA channel |
| idle | output | 1 | Parser stopped and empty |

## Verification
Two events can fall in the same cycle: capture of a new frame's start marker and an active walk of the previous frame. Both also meet the clearing of `enable` in the middle of a frame. The bench provokes the first case by starting a long walk over a table of 200 pass-through entries and then sending a second frame five cycles later. It judges the result by counting verdict pulses over a long window; exactly one must appear. For the second case, the bench drops `enable` after the first word of a frame. It then checks that `idle` stays low, that the rule-derived verdict still arrives, and that `idle` rises in the same cycle that the verdict is seen.

// File: rtl/frame_parser.sv
module frame_parser #(
  parameter int DEPTH     = 256,
  parameter int MAX_WORDS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic [7:0]  nve,
  input  logic [7:0]  npe,
  input  logic        rx_valid,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic [31:0] rx_data,
  output logic [7:0]  tbl_idx,
  input  logic [91:0] tbl_entry,
  output logic        vd_valid,
  output logic        vd_accept,
  output logic [7:0]  vd_chan,
  output logic        idle
);

  localparam int AW = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;
  localparam int LW = $clog2(MAX_WORDS + 1);
  localparam int SW = $clog2(DEPTH + 1);

  typedef enum logic [1:0] {S_IDLE, S_CAP, S_WALK} state_t;

  state_t         st_q;
  logic [8:0]     idx_q;
  logic [SW-1:0]  steps_q;
  logic [LW-1:0]  len_q;
  logic [31:0]    words_q [MAX_WORDS];

  logic [31:0] e_pat, e_mask;
  logic [7:0]  e_off, e_jump, e_chan;
  logic        e_acc, e_rej, e_inv, e_chain;

  assign e_pat   = tbl_entry[91:60];
  assign e_mask  = tbl_entry[59:28];
  assign e_off   = tbl_entry[27:20];
  assign e_jump  = tbl_entry[19:12];
  assign e_chan  = tbl_entry[11:4];
  assign e_acc   = tbl_entry[3];
  assign e_rej   = tbl_entry[2];
  assign e_inv   = tbl_entry[1];
  assign e_chain = tbl_entry[0];

  assign tbl_idx = idx_q[7:0];
  assign idle    = !enable && (st_q == S_IDLE);

  logic        start, store;
  logic [31:0] cur_word;
  logic [7:0]  limit;
  logic        hit, at_end;

  assign start = (st_q == S_IDLE) && enable && rx_valid && rx_sof;
  assign store = start || ((st_q == S_CAP) && rx_valid && (len_q < LW'(MAX_WORDS)));
  assign limit = (nve < npe) ? nve : npe;

  assign cur_word = ({1'b0, e_off} < 9'(len_q)) ? words_q[e_off[AW-1:0]] : 32'h0;
  assign hit      = ((((cur_word ^ e_pat) & e_mask) == 32'h0)) ^ e_inv;
  assign at_end   = (idx_q >= {1'b0, limit}) || (steps_q >= SW'(DEPTH));

  logic       done, d_acc;
  logic [7:0] d_chan;
  logic [8:0] nxt_idx;

  always_comb begin
    done    = 1'b0;
    d_acc   = 1'b1;
    d_chan  = 8'h0;
    nxt_idx = idx_q + 9'd1;
    if (at_end) begin
      done = 1'b1;
    end else if (e_chain) begin
      nxt_idx = hit ? {1'b0, e_jump} : ({1'b0, e_jump} + 9'd1);
    end else if (hit && e_acc) begin
      done   = 1'b1;
      d_chan = e_chan;
    end else if (hit && e_rej) begin
      done  = 1'b1;
      d_acc = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (store) words_q[start ? AW'(0) : len_q[AW-1:0]] <= rx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      idx_q     <= '0;
      steps_q   <= '0;
      len_q     <= '0;
      vd_valid  <= 1'b0;
      vd_accept <= 1'b0;
      vd_chan   <= '0;
    end else begin
      vd_valid <= 1'b0;
      case (st_q)
        S_IDLE: if (start) begin
          len_q   <= LW'(1);
          idx_q   <= '0;
          steps_q <= '0;
          st_q    <= rx_eof ? S_WALK : S_CAP;
        end
        S_CAP: if (rx_valid) begin
          if (len_q < LW'(MAX_WORDS)) len_q <= len_q + LW'(1);
          if (rx_eof) st_q <= S_WALK;
        end
        S_WALK: begin
          if (done) begin
            vd_valid  <= 1'b1;
            vd_accept <= d_acc;
            vd_chan   <= d_chan;
            st_q      <= S_IDLE;
          end else begin
            idx_q   <= nxt_idx;
            steps_q <= steps_q + SW'(1);
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/parser_checker.sv
module parser_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       idle,
  input logic       vd_valid,
  input logic       vd_accept,
  input logic [7:0] vd_chan
);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    vd_valid |=> !vd_valid);

  a_r3_drop_chan_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (vd_valid && !vd_accept) |-> (vd_chan == 8'h0));

  a_r10_idle_needs_off: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !enable);

  a_r9_quiet_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $past(idle) |-> !vd_valid);

  a_r1_no_pulse_in_reset: assert property (@(posedge clk)
    !rst_n |=> !vd_valid);

endmodule

bind frame_parser parser_checker u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .idle(idle),
  .vd_valid(vd_valid), .vd_accept(vd_accept), .vd_chan(vd_chan)
);

// File: tb/frame_parser_tb.sv
module frame_parser_tb;
  localparam int MAXW  = 16;
  localparam int DEPTH = 256;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, enable, rx_valid, rx_sof, rx_eof;
  logic [7:0]  nve, npe, tbl_idx, vd_chan;
  logic [31:0] rx_data;
  logic [91:0] tbl_entry;
  logic        vd_valid, vd_accept, idle;

  logic [91:0] tbl [256];
  logic [31:0] fw [64];
  int          flen;
  int          n_run = 0, n_fail = 0;
  bit          finished = 0;

  assign tbl_entry = tbl[tbl_idx];

  frame_parser #(.DEPTH(DEPTH), .MAX_WORDS(MAXW)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .nve(nve), .npe(npe),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
    .tbl_idx(tbl_idx), .tbl_entry(tbl_entry),
    .vd_valid(vd_valid), .vd_accept(vd_accept), .vd_chan(vd_chan), .idle(idle));

  function automatic logic [91:0] mk(logic [31:0] d, logic [31:0] m, int off, int jmp,
                                     int ch, logic acc, logic rej, logic inv, logic chn);
    return {d, m, 8'(off), 8'(jmp), 8'(ch), acc, rej, inv, chn};
  endfunction

  function automatic void model(int nv, int np, output logic acc, output int ch);
    int idx = 0, steps = 0;
    int lim = (nv < np) ? nv : np;
    int stored = (flen < MAXW) ? flen : MAXW;
    while (1) begin
      logic [91:0] e;
      logic [31:0] w;
      logic mm;
      if (idx >= lim || steps >= DEPTH) begin acc = 1; ch = 0; return; end
      e = tbl[idx];
      w = (int'(e[27:20]) < stored) ? fw[e[27:20]] : 32'h0;
      mm = ((((w ^ e[91:60]) & e[59:28]) == 32'h0)) ^ e[1];
      if (e[0]) idx = mm ? int'(e[19:12]) : int'(e[19:12]) + 1;
      else if (mm && e[3]) begin acc = 1; ch = int'(e[11:4]); return; end
      else if (mm && e[2]) begin acc = 0; ch = 0; return; end
      else idx++;
      steps++;
    end
  endfunction

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp, string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic clear_tbl();
    for (int i = 0; i < 256; i++) tbl[i] = '0;
  endtask

  task automatic send(int n);
    for (int w = 0; w < n; w++) begin
      rx_valid = 1; rx_sof = (w == 0); rx_eof = (w == n - 1); rx_data = fw[w];
      @(negedge clk);
    end
    rx_valid = 0; rx_sof = 0; rx_eof = 0;
  endtask

  task automatic wait_vd(output bit got);
    got = 0;
    for (int i = 0; i < 400; i++) begin
      if (vd_valid) begin got = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic count_vd(int cyc, output int n);
    n = 0;
    for (int i = 0; i < cyc; i++) begin
      if (vd_valid) n++;
      @(negedge clk);
    end
  endtask

  task automatic run_check(string rq, int nv, int np);
    bit got; logic ea; int ec;
    nve = 8'(nv); npe = 8'(np);
    send(flen);
    wait_vd(got);
    model(nv, np, ea, ec);
    check(rq, 32'(got), 32'd1, "verdict seen");
    check(rq, 32'(vd_accept), 32'(ea), "accept");
    check(rq, 32'(vd_chan), 32'(ec), "channel");
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    bit got;
    void'($urandom(32'd2024));
    rst_n = 0; enable = 0; rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_data = 0;
    nve = 4; npe = 4;
    clear_tbl();
    for (int i = 0; i < 64; i++) fw[i] = 0;
    repeat (3) @(negedge clk);
    check("R1", 32'(vd_valid), 0, "vd_valid in reset");
    rst_n = 1;
    @(negedge clk);
    check("R1", 32'(idle), 1, "idle after reset");
    check("R1", 32'(vd_valid), 0, "vd_valid after reset");
    enable = 1;
    @(negedge clk);

    // R2 basic deliver
    fw[0] = 32'h11223344; fw[1] = 32'hAABBCCDD; flen = 2;
    tbl[0] = mk(32'hAABB0000, 32'hFFFF0000, 1, 0, 5, 1, 0, 0, 0);
    run_check("R2", 4, 4);
    // R3 drop, then both flags
    tbl[0] = mk(32'h11223344, 32'hFFFFFFFF, 0, 0, 6, 0, 1, 0, 0);
    run_check("R3", 4, 4);
    tbl[0] = mk(32'h11223344, 32'hFFFFFFFF, 0, 0, 6, 1, 1, 0, 0);
    run_check("R3", 4, 4);
    // R4 inverse
    tbl[0] = mk(32'h0, 32'hFFFFFFFF, 0, 0, 8, 1, 0, 1, 0);
    run_check("R4", 4, 4);
    tbl[0] = mk(32'h11223344, 32'hFFFFFFFF, 0, 0, 8, 1, 0, 1, 0);
    run_check("R4", 4, 4);
    // R5 hit with no verdict falls through
    tbl[0] = mk(32'h11223344, 32'hFFFFFFFF, 0, 0, 9, 0, 0, 0, 0);
    tbl[1] = mk(0, 0, 0, 0, 3, 1, 0, 0, 0);
    run_check("R5", 4, 4);

    // R6 chained halves
    clear_tbl();
    fw[2] = 32'h01020304; fw[3] = 32'h05060708; flen = 4;
    tbl[0] = mk(32'h01020000, 32'hFFFF0000, 2, 2, 0, 0, 0, 0, 1);
    tbl[1] = mk(0, 0, 0, 0, 7, 1, 0, 0, 0);
    tbl[2] = mk(32'h00000708, 32'h0000FFFF, 3, 0, 9, 1, 0, 0, 0);
    tbl[3] = mk(0, 0, 0, 0, 4, 1, 0, 0, 0);
    run_check("R6", 8, 8);
    fw[3] = 32'h05060709;
    run_check("R6", 8, 8);
    fw[3] = 32'h05060708; fw[2] = 32'h01030304;
    run_check("R6", 8, 8);

    // R7 limits and step cap
    clear_tbl();
    fw[0] = 32'h1; flen = 1;
    tbl[0] = mk(32'hDEAD, 32'hFFFFFFFF, 0, 0, 1, 1, 0, 0, 0);
    tbl[1] = mk(0, 0, 0, 0, 7, 1, 0, 0, 0);
    run_check("R7", 1, 4);
    run_check("R7", 4, 1);
    run_check("R7", 4, 4);
    tbl[0] = mk(0, 0, 0, 0, 0, 0, 0, 0, 1);
    run_check("R7", 8, 8);

    // R8 stale words and capacity
    clear_tbl();
    for (int i = 0; i < 8; i++) fw[i] = 32'hC0DE0000 + i;
    flen = 8; run_check("R8", 4, 4);
    flen = 2;
    tbl[0] = mk(0, 32'hFFFFFFFF, 5, 0, 2, 1, 0, 0, 0);
    run_check("R8", 4, 4);
    for (int i = 0; i < 20; i++) fw[i] = 32'h12345678;
    flen = 20;
    tbl[0] = mk(32'h12345678, 32'hFFFFFFFF, 17, 0, 3, 1, 0, 0, 0);
    run_check("R8", 4, 4);

    // R9 start while busy is ignored
    clear_tbl();
    nve = 200; npe = 200;
    send(1);
    repeat (5) @(negedge clk);
    send(2);
    count_vd(600, n);
    check("R9", 32'(n), 1, "verdicts for overlapping frames");

    // R10 / R9 disabled
    enable = 0;
    @(negedge clk);
    check("R10", 32'(idle), 1, "idle while off");
    flen = 2; send(2);
    count_vd(300, n);
    check("R9", 32'(n), 0, "verdicts while disabled");
    check("R10", 32'(idle), 1, "idle after ignored frame");

    // R10 enable dropped mid-frame
    enable = 1; nve = 4; npe = 4;
    fw[0] = 32'h55; fw[1] = 32'h66; fw[2] = 32'h77;
    tbl[0] = mk(32'h66, 32'hFF, 1, 0, 5, 1, 0, 0, 0);
    rx_valid = 1; rx_sof = 1; rx_eof = 0; rx_data = fw[0];
    @(negedge clk);
    enable = 0;
    rx_sof = 0; rx_data = fw[1];
    @(negedge clk);
    rx_eof = 1; rx_data = fw[2];
    @(negedge clk);
    rx_valid = 0; rx_eof = 0;
    check("R10", 32'(idle), 0, "idle during in-flight frame");
    wait_vd(got);
    check("R10", 32'(got), 1, "verdict after disable");
    check("R10", 32'(vd_chan), 5, "channel after disable");
    check("R10", 32'(idle), 1, "idle after last verdict");
    enable = 1;
    @(negedge clk);

    // Random mix (R2 R4 R5 R6 R7 R8)
    for (int t = 0; t < 200; t++) begin
      int stored;
      flen = 1 + int'($urandom % 20);
      stored = (flen < MAXW) ? flen : MAXW;
      for (int i = 0; i < 20; i++) fw[i] = $urandom;
      clear_tbl();
      for (int e = 0; e < 16; e++) begin
        int off = int'($urandom % 20);
        logic [31:0] m, d;
        case ($urandom % 4)
          0: m = 32'h0;
          1: m = 32'hFF << (8 * ($urandom % 4));
          2: m = 32'hFFFFFFFF;
          default: m = $urandom & $urandom;
        endcase
        d = (off < stored) ? fw[off] : 32'h0;
        if ($urandom % 3 == 0) d = d ^ (32'h1 << ($urandom % 32));
        tbl[e] = mk(d, m, off, int'($urandom % 16), int'($urandom % 256),
                    1'($urandom), 1'($urandom), ($urandom % 6) == 0, ($urandom % 5) == 0);
      end
      run_check("R2", 1 + int'($urandom % 16), 1 + int'($urandom % 16));
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule